// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits between a processor's register bus and the slot layer of an AC'97 link. Software reaches the 16-bit registers inside a codec through two 32-bit words. The control word holds a read/write selector, a 7-bit register index, 16 bits of write data and a handshake flag. Setting the flag launches the command. The controller places the command in the command slots of the next outgoing frame and then drops the flag, so software can poll the flag to see when the command has left. The status word returns the index and data of the latest read response from the codec. It also carries a fresh-data flag that is raised only when the response belongs to the last read that was sent. Two codec-ready bits are refreshed once per incoming frame.

A warm link reset goes through the same handshake. A control write that sets both the warm-reset bit and the handshake flag drives a sync pulse for a parameterised number of clocks, and then the flag drops. The link-shutdown bit and the two codec power-down bits are plain levels passed to the link layer. The slot interfaces are parallel: an outgoing frame strobe, a command address/data pair with a one-cycle valid, and an incoming frame strobe with a tagged response address/data pair. Software normally allows about a millisecond for either the handshake or the read reply before it gives up.

Top module: `codec_reg_ctrl`

## Requirements
- R1: After reset, ctl_rdata and sts_rdata read 0, and cmd_valid, sync_pulse, link_shutdown, pwrdn_pri and pwrdn_sec are all 0.
- R2: A control write accepted while bit 16 reads 0 stores the word. Readback gives bit 31 (1 = read, 0 = write), bits 30:24 (register index), bits 21, 20, 18, 17 and 16, and bits 15:0 (write data). Bits 23:22 and 19 read 0.
- R3: The outputs pwrdn_pri, pwrdn_sec and link_shutdown follow stored control bits 21, 20 and 18.
- R4: While control bit 16 is 1 and bit 17 is 0, the first cycle with frame_out_stb makes cmd_valid high for exactly the next cycle. In that cycle cmd_addr = {bit 31, bits 30:24} and cmd_data = the write data, or 0 for a read, and bit 16 reads 0 from that cycle on. Without a strobe, nothing is sent and bit 16 stays 1.
- R5: A control write while bit 16 reads 1 is ignored, and the pending command is sent unchanged.
- R6: An accepted write with bits 17 and 16 both set raises sync_pulse from the next cycle for exactly WARM_CLKS cycles. When sync_pulse falls, bits 17 and 16 read 0. No cmd_valid is produced.
- R7: On a frame_in_stb cycle with rsp_valid, the next cycle shows status bits 31:24 = {0, rsp_addr} and bits 15:0 = rsp_data.
- R8: Status bit 17 (fresh) is set only by a captured response whose index equals that of the last read command sent, with no new command accepted since. A response to any other index, or one that arrives before the read is sent, leaves bit 17 at 0.
- R9: Fresh clears on a sts_rd strobe or on an accepted control write with bit 16 set. The accepted command wins over a matching response in the same cycle. A matching response wins over sts_rd in the same cycle.
- R10: Status bits 23 and 22 take codec_rdy_pri and codec_rdy_sec on frame_in_stb cycles only, and hold between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| sts_rd | input | 1 | Status read strobe (clears fresh flag) |
| sts_rdata | output | 32 | Status word |
| frame_out_stb | input | 1 | Outgoing frame command-slot strobe |
| cmd_valid | output | 1 | Command slots carry a command this cycle |
| cmd_addr | output | 8 | Command address slot: read flag and register index |
| cmd_data | output | 16 | Command data slot |
| frame_in_stb | input | 1 | Incoming frame strobe |
| rsp_valid | input | 1 | Incoming frame carries a tagged register reply |
| rsp_addr | input | 7 | Register index of the reply |
| rsp_data | input | 16 | Register data of the reply |
| codec_rdy_pri | input | 1 | Primary codec ready indication |
| codec_rdy_sec | input | 1 | Secondary codec ready indication |
| sync_pulse | output | 1 | Warm-reset sync drive |
| link_shutdown | output | 1 | Link shutdown request level |
| pwrdn_pri | output | 1 | Primary codec power-down level |
| pwrdn_sec | output | 1 | Secondary codec power-down level |

## Verification
If the handshake flag is stuck, it shows at the ports within one frame strobe: either cmd_valid never follows the strobe, or bit 16 never drops and later writes are silently lost. If the stored read index or the armed state is wrong, only the status fresh bit reveals it, one cycle after the reply frame, so the checks pair every reply with a read of bit 17, including replies with a foreign index and replies that arrive early. If the warm-reset timer miscounts, the pulse length, measured in cycles against WARM_CLKS, shows it right away.

// File: rtl/codec_acc_pkg.sv
package codec_acc_pkg;

    localparam int IDX_W  = 7;
    localparam int DATA_W = 16;

    // control word, bit positions fixed by software
    typedef struct packed {
        logic              rd;        // 31
        logic [IDX_W-1:0]  idx;       // 30:24
        logic [1:0]        rsv_hi;    // 23:22
        logic              pd_pri;    // 21
        logic              pd_sec;    // 20
        logic              rsv_mid;   // 19
        logic              shut;      // 18
        logic              warm;      // 17
        logic              new_cmd;   // 16
        logic [DATA_W-1:0] data;      // 15:0
    } ctl_t;

    // status word
    typedef struct packed {
        logic [IDX_W:0]    idx;       // 31:24
        logic              pri_rdy;   // 23
        logic              sec_rdy;   // 22
        logic [3:0]        rsv_hi;    // 21:18
        logic              fresh;     // 17
        logic              rsv_lo;    // 16
        logic [DATA_W-1:0] data;      // 15:0
    } sts_t;

    localparam logic [31:0] CTL_WR_MASK = 32'hFF37_FFFF;

    function automatic ctl_t ctl_from_word(input logic [31:0] w);
        return ctl_t'(w & CTL_WR_MASK);
    endfunction

endpackage

// File: rtl/acc_sync_timer.sv
module acc_sync_timer #(
    parameter int CLKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic sync_o,
    output logic done
);
    localparam int CW = $clog2(CLKS + 1);

    logic [CW-1:0] cnt;
    logic          active;

    assign sync_o = active;
    assign done   = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            cnt    <= CW'(CLKS - 1);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    // R6: the pulse never ends without its final count
    p_sync_end_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(cnt) == '0);

endmodule

// File: rtl/acc_cmd_unit.sv
module acc_cmd_unit
    import codec_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    input  logic              frame_out_stb,
    input  logic              warm_done,
    output ctl_t              ctl_q,
    output logic              accept_cmd,
    output logic              warm_start,
    output logic              launch_rd,
    output logic              cmd_valid,
    output logic [IDX_W:0]    cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    ctl_t wr_word;
    logic accept;
    logic launch;

    assign wr_word    = ctl_from_word(ctl_wdata);
    assign accept     = ctl_wr && !ctl_q.new_cmd;
    assign accept_cmd = accept && wr_word.new_cmd;
    assign warm_start = accept_cmd && wr_word.warm;
    assign launch     = ctl_q.new_cmd && !ctl_q.warm && frame_out_stb;
    assign launch_rd  = launch && ctl_q.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= launch;
            if (accept) begin
                ctl_q <= wr_word;
            end else if (launch) begin
                ctl_q.new_cmd <= 1'b0;
                cmd_addr      <= {ctl_q.rd, ctl_q.idx};
                cmd_data      <= ctl_q.rd ? '0 : ctl_q.data;
            end else if (warm_done) begin
                ctl_q.new_cmd <= 1'b0;
                ctl_q.warm    <= 1'b0;
            end
        end
    end

    p_busy_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.new_cmd && ctl_wr) |=>
            ($stable(ctl_q.idx) && $stable(ctl_q.data) && $stable(ctl_q.rd)));

    p_launch_handshake_r4: assert property (@(posedge clk) disable iff (rst)
        launch |=> (cmd_valid && !ctl_q.new_cmd));

    p_valid_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(frame_out_stb));

endmodule

// File: rtl/acc_rsp_unit.sv
module acc_rsp_unit
    import codec_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_in_stb,
    input  logic              rsp_valid,
    input  logic [IDX_W-1:0]  rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rdy_pri,
    input  logic              rdy_sec,
    input  logic              sts_rd,
    input  logic              arm,
    input  logic [IDX_W-1:0]  arm_idx,
    input  logic              disarm,
    output sts_t              sts_q
);
    logic             armed;
    logic [IDX_W-1:0] exp_idx;
    logic             got;
    logic             hit;

    assign got = frame_in_stb && rsp_valid;
    assign hit = got && armed && (rsp_addr == exp_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            exp_idx <= '0;
            sts_q   <= '0;
        end else begin
            if (disarm) begin
                armed <= 1'b0;
            end else if (arm) begin
                armed   <= 1'b1;
                exp_idx <= arm_idx;
            end

            if (disarm)      sts_q.fresh <= 1'b0;
            else if (hit)    sts_q.fresh <= 1'b1;
            else if (sts_rd) sts_q.fresh <= 1'b0;

            if (got) begin
                sts_q.idx  <= {1'b0, rsp_addr};
                sts_q.data <= rsp_data;
            end
            if (frame_in_stb) begin
                sts_q.pri_rdy <= rdy_pri;
                sts_q.sec_rdy <= rdy_sec;
            end
        end
    end

    p_fresh_needs_match_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q.fresh) |-> $past(got && rsp_addr == exp_idx));

    p_ready_sampled_r10: assert property (@(posedge clk) disable iff (rst)
        frame_in_stb |=> (sts_q.pri_rdy == $past(rdy_pri)) && (sts_q.sec_rdy == $past(rdy_sec)));

    p_ready_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_in_stb |=> ($stable(sts_q.pri_rdy) && $stable(sts_q.sec_rdy)));

endmodule

// File: rtl/codec_reg_ctrl.sv
module codec_reg_ctrl
    import codec_acc_pkg::*;
#(
    parameter int WARM_CLKS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        sts_rd,
    output logic [31:0] sts_rdata,
    input  logic        frame_out_stb,
    output logic        cmd_valid,
    output logic [7:0]  cmd_addr,
    output logic [15:0] cmd_data,
    input  logic        frame_in_stb,
    input  logic        rsp_valid,
    input  logic [6:0]  rsp_addr,
    input  logic [15:0] rsp_data,
    input  logic        codec_rdy_pri,
    input  logic        codec_rdy_sec,
    output logic        sync_pulse,
    output logic        link_shutdown,
    output logic        pwrdn_pri,
    output logic        pwrdn_sec
);
    ctl_t ctl_q;
    sts_t sts_q;
    logic accept_cmd, warm_start, warm_done, launch_rd;

    acc_cmd_unit u_cmd (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .frame_out_stb(frame_out_stb), .warm_done(warm_done),
        .ctl_q(ctl_q), .accept_cmd(accept_cmd), .warm_start(warm_start),
        .launch_rd(launch_rd), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    acc_sync_timer #(.CLKS(WARM_CLKS)) u_sync (
        .clk(clk), .rst(rst), .start(warm_start),
        .sync_o(sync_pulse), .done(warm_done)
    );

    acc_rsp_unit u_rsp (
        .clk(clk), .rst(rst),
        .frame_in_stb(frame_in_stb), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rdy_pri(codec_rdy_pri), .rdy_sec(codec_rdy_sec),
        .sts_rd(sts_rd), .arm(launch_rd), .arm_idx(ctl_q.idx),
        .disarm(accept_cmd), .sts_q(sts_q)
    );

    assign ctl_rdata     = ctl_q;
    assign sts_rdata     = sts_q;
    assign link_shutdown = ctl_q.shut;
    assign pwrdn_pri     = ctl_q.pd_pri;
    assign pwrdn_sec     = ctl_q.pd_sec;

    p_sync_with_warm_r6: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> (ctl_rdata[17] && ctl_rdata[16]));

    p_no_slot_in_warm_r6: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> !cmd_valid);

    p_cmd_clears_fresh_r9: assert property (@(posedge clk) disable iff (rst)
        accept_cmd |=> !sts_rdata[17]);

endmodule

// File: tb/test_codec_reg_ctrl.sv
module test_codec_reg_ctrl;
    localparam int W = 6;
    localparam logic [31:0] MASK = 32'hFF37_FFFF;
    localparam logic [31:0] VW [W] = '{32'h0201_8000, 32'h9C01_0000, 32'h7E01_FFFF,
                                       32'hFC01_0000, 32'h8001_1234, 32'h2C01_BB80};
    localparam logic [15:0] VR [W] = '{16'h0000, 16'h0F0F, 16'h0000,
                                       16'h414C, 16'h6A90, 16'h0000};

    logic clk = 0, rst = 1;
    logic ctl_wr = 0, sts_rd = 0, frame_out_stb = 0, frame_in_stb = 0, rsp_valid = 0;
    logic [31:0] ctl_wdata = 0;
    logic [6:0]  rsp_addr = 0;
    logic [15:0] rsp_data = 0;
    logic rdy_p = 0, rdy_s = 0;
    logic [31:0] ctl_rdata, sts_rdata;
    logic cmd_valid, sync_pulse, link_shutdown, pwrdn_pri, pwrdn_sec;
    logic [7:0] cmd_addr;
    logic [15:0] cmd_data;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    codec_reg_ctrl #(.WARM_CLKS(16)) i_codec_reg_ctrl (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_rd(sts_rd), .sts_rdata(sts_rdata), .frame_out_stb(frame_out_stb),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .frame_in_stb(frame_in_stb), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .codec_rdy_pri(rdy_p), .codec_rdy_sec(rdy_s),
        .sync_pulse(sync_pulse), .link_shutdown(link_shutdown),
        .pwrdn_pri(pwrdn_pri), .pwrdn_sec(pwrdn_sec));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] w);
        @(negedge clk); ctl_wr = 1; ctl_wdata = w;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic out_frame();
        @(negedge clk); frame_out_stb = 1;
        @(negedge clk); frame_out_stb = 0;
    endtask

    task automatic in_frame(input logic v, input logic [6:0] a, input logic [15:0] d,
                            input logic rd_too);
        @(negedge clk); frame_in_stb = 1; rsp_valid = v; rsp_addr = a; rsp_data = d; sts_rd = rd_too;
        @(negedge clk); frame_in_stb = 0; rsp_valid = 0; sts_rd = 0;
    endtask

    task automatic rd_sts();
        @(negedge clk); sts_rd = 1;
        @(negedge clk); sts_rd = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 sts", sts_rdata, 0);
        chk("R1 outs", {31'd0, cmd_valid | sync_pulse | link_shutdown | pwrdn_pri | pwrdn_sec}, 0);

        // vector table walk
        for (int i = 0; i < W; i++) begin
            logic [31:0] w;
            w = VW[i];
            wr_ctl(w);
            chk("R2 readback", ctl_rdata, w & MASK);
            out_frame();
            chk("R4 valid", {31'd0, cmd_valid}, 1);
            chk("R4 addr", {24'd0, cmd_addr}, {24'd0, w[31:24]});
            chk("R4 data", {16'd0, cmd_data}, {16'd0, w[31] ? 16'h0 : w[15:0]});
            chk("R4 flag clear", {31'd0, ctl_rdata[16]}, 0);
            @(negedge clk);
            chk("R4 single cycle", {31'd0, cmd_valid}, 0);
            if (w[31]) begin
                in_frame(1, w[30:24], VR[i], 0);
                chk("R7 idx", {24'd0, sts_rdata[31:24]}, {25'd0, w[30:24]});
                chk("R7 data", {16'd0, sts_rdata[15:0]}, {16'd0, VR[i]});
                chk("R8 fresh", {31'd0, sts_rdata[17]}, 1);
                rd_sts();
                chk("R9 read clears", {31'd0, sts_rdata[17]}, 0);
            end
        end

        // R4 no launch without strobe, R5 busy write ignored
        wr_ctl(32'hA601_0000);
        repeat (3) @(negedge clk);
        chk("R4 no strobe", {31'd0, cmd_valid}, 0);
        chk("R4 pending", {31'd0, ctl_rdata[16]}, 1);
        wr_ctl(32'h0001_1234);
        chk("R5 ignored", ctl_rdata, 32'hA601_0000);
        out_frame();
        chk("R5 sent addr", {24'd0, cmd_addr}, 32'h0000_00A6);
        chk("R5 sent data", {16'd0, cmd_data}, 0);

        // R8 foreign reply, then matching reply; R9 set beats read
        in_frame(1, 7'h05, 16'hAAAA, 0);
        chk("R7 foreign idx", {24'd0, sts_rdata[31:24]}, 32'h05);
        chk("R8 foreign not fresh", {31'd0, sts_rdata[17]}, 0);
        in_frame(1, 7'h26, 16'h5555, 1);
        chk("R9 set beats read", {31'd0, sts_rdata[17]}, 1);
        rd_sts();
        chk("R9 read clear", {31'd0, sts_rdata[17]}, 0);
        // R9 new command clears fresh
        in_frame(1, 7'h26, 16'h1111, 0);
        chk("R8 refresh", {31'd0, sts_rdata[17]}, 1);
        wr_ctl(32'h9001_0000);
        chk("R9 cmd clears", {31'd0, sts_rdata[17]}, 0);
        // R8 reply before the read is sent
        in_frame(1, 7'h10, 16'h2222, 0);
        chk("R8 early reply", {31'd0, sts_rdata[17]}, 0);
        out_frame();
        in_frame(0, 7'h10, 16'h3333, 0);
        chk("R7 no valid no capture", {16'd0, sts_rdata[15:0]}, 32'h2222);

        // R10 ready bits
        rdy_p = 1; rdy_s = 0;
        in_frame(0, 0, 0, 0);
        chk("R10 sampled", {30'd0, sts_rdata[23:22]}, 2);
        rdy_p = 0; rdy_s = 1;
        repeat (3) @(negedge clk);
        chk("R10 hold", {30'd0, sts_rdata[23:22]}, 2);
        in_frame(0, 0, 0, 0);
        chk("R10 resampled", {30'd0, sts_rdata[23:22]}, 1);

        // R3 level outputs
        wr_ctl(32'h0034_0000);
        chk("R3 levels", {29'd0, pwrdn_pri, pwrdn_sec, link_shutdown}, 7);
        wr_ctl(32'h0020_0000);
        chk("R3 partial", {29'd0, pwrdn_pri, pwrdn_sec, link_shutdown}, 4);

        // R6 warm reset
        begin
            int n;
            int seen;
            n = 0; seen = 0;
            wr_ctl(32'h0003_0000);
            while (sync_pulse && n < 100) begin
                n++;
                if (cmd_valid) seen++;
                frame_out_stb = 1;
                @(negedge clk);
            end
            frame_out_stb = 0;
            chk("R6 length", n, 16);
            chk("R6 no slot", seen, 0);
            chk("R6 bits clear", {30'd0, ctl_rdata[17:16]}, 0);
            @(negedge clk);
            chk("R6 no slot after", {31'd0, cmd_valid}, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule